// File: doc/BRIEF.md
# Isolated I/O Bus Cycle Sequencer

This block generates the bus cycles for the port input and port output instructions of a small 8-bit processor that keeps memory and I/O in separate address spaces. A one-cycle `start` pulse, with `is_out` choosing the direction, launches three machine cycles in a fixed order:

- an opcode fetch;
- a memory read that brings in the port number byte;
- an I/O read or an I/O write to that port.

Each machine cycle has three T-states, so each takes three clocks. The block drives a 16-bit address, a space-select line that is high only for the I/O cycle, and active-low read and write strobes. For an input instruction it loads the byte returned by the port into its accumulator. For an output instruction it drives the accumulator onto the write data bus.

An internal program counter supplies the address for the two memory reads and advances once per fetched byte. During the I/O cycle the port number is placed on both halves of the address bus. Decoders downstream can then select a port from either byte. A `busy` level covers all nine T-states, and a one-cycle `done` pulse follows them.

Top module: `iocyc_seq`

## Requirements
- R1: After `start` is accepted, the block runs nine busy clocks: opcode fetch T1..T3, operand read T1..T3, then I/O cycle T1..T3. `busy` is high for exactly those nine clocks. `done` is high for the single clock that follows them, and `busy` is low during that clock.
- R2: `io_sel` is 1 for the three clocks of the I/O cycle and 0 at all other times.
- R3: The opcode fetch drives the program counter on `addr`, and the operand read drives the program counter plus one. The counter resets to 0, grows by 2 per instruction and wraps modulo 2^16.
- R4: During the I/O cycle, `addr[7:0]` and `addr[15:8]` both carry the port number. The port number is the `rd_data` byte sampled on the clock edge that ends T3 of the operand read.
- R5: The strobes are high in T1 of every machine cycle and low in T2 and T3 of it. `rd_n` is the strobe for the opcode fetch, for the operand read and for the I/O cycle of an input. `wr_n` is the strobe only for the I/O cycle of an output (`is_out`=1). The two strobes are never low together.
- R6: For an input (`is_out`=0), the `rd_data` byte on the edge that ends T3 of the I/O cycle is loaded into the accumulator, and `acc` shows it from the `done` clock on. The accumulator changes at no other time.
- R7: For an output, `wr_oe` is 1 and `wr_data` equals the accumulator during T2 and T3 of the I/O cycle. `wr_oe` is 0 at all other times.
- R8: `start` is accepted only while the block is idle. A `start` seen while `busy` or `done` is high has no effect: the instruction in progress keeps its direction, and the block is idle in the clock after `done`. `is_out` is sampled together with an accepted `start`.
- R9: After reset, `busy`, `done`, `io_sel` and `wr_oe` are 0, `rd_n` and `wr_n` are 1, and `acc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run one port instruction |
| is_out | input | 1 | 1 selects output, 0 selects input; sampled with start |
| rd_data | input | 8 | Read data bus |
| addr | output | 16 | Address bus |
| io_sel | output | 1 | 1 for the I/O space, 0 for memory |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| wr_data | output | 8 | Write data bus (accumulator) |
| wr_oe | output | 1 | Write data drive enable |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-clock completion pulse |
| acc | output | 8 | Accumulator contents |

## Verification
The assertions assume that `start` is a clean synchronous level and that `rd_data` is settled on the edge that samples it. They make no assumption about how often requests arrive.

The bench drives every input at the falling edge and holds `rd_data` for a whole T-state. It mixes random directions, ports and input data with directed extremes: port 00h, port FFh, and bursts of input followed by output.

Some requests are placed on purpose while `busy` and while `done` are high. The design must reject these, so the checks still expect a single clean sequence for them.

// File: rtl/iocyc_pkg.sv
package iocyc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FETCH = 3'd1,
    PH_OPER  = 3'd2,
    PH_IO    = 3'd3,
    PH_DONE  = 3'd4
  } io_phase_e;
endpackage

// File: rtl/iocyc_ctrl.sv
module iocyc_ctrl
  import iocyc_pkg::*;
#(
  parameter int T_STATES = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      is_out,
  output io_phase_e phase,
  output logic      t_first,
  output logic      t_last,
  output logic      op_out
);
  localparam int TW = (T_STATES > 1) ? $clog2(T_STATES) : 1;
  localparam logic [TW-1:0] T_END = TW'(T_STATES - 1);

  io_phase_e     phase_q, phase_d;
  logic [TW-1:0] t_q, t_d;
  logic          op_q, op_d;

  assign t_first = (t_q == '0);
  assign t_last  = (t_q == T_END);

  always_comb begin
    phase_d = phase_q;
    t_d     = t_q;
    op_d    = op_q;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_FETCH;
        t_d     = '0;
        op_d    = is_out;
      end
      PH_FETCH, PH_OPER, PH_IO: begin
        if (t_q == T_END) begin
          t_d = '0;
          unique case (phase_q)
            PH_FETCH: phase_d = PH_OPER;
            PH_OPER:  phase_d = PH_IO;
            default:  phase_d = PH_DONE;
          endcase
        end else begin
          t_d = t_q + 1'b1;
        end
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      t_q     <= '0;
      op_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      t_q     <= t_d;
      op_q    <= op_d;
    end
  end

  assign phase  = phase_q;
  assign op_out = op_q;
endmodule

// File: rtl/iocyc_addr.sv
module iocyc_addr
  import iocyc_pkg::*;
#(
  parameter int            PORT_W = 8,
  parameter int            ADDR_W = 2 * PORT_W,
  parameter logic [ADDR_W-1:0] PC_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  io_phase_e         phase,
  input  logic              t_last,
  input  logic [PORT_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr
);
  localparam int COPIES = ADDR_W / PORT_W;

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic [ADDR_W-1:0] io_addr;
  logic              pc_en, port_en;

  assign pc_en   = t_last && (phase == PH_FETCH || phase == PH_OPER);
  assign port_en = t_last && (phase == PH_OPER);

  always_comb begin
    pc_d   = pc_en   ? pc_q + 1'b1 : pc_q;
    port_d = port_en ? rd_data     : port_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= PC_RESET;
      port_q <= '0;
    end else begin
      pc_q   <= pc_d;
      port_q <= port_d;
    end
  end

  for (genvar g = 0; g < COPIES; g++) begin : g_dup
    assign io_addr[g*PORT_W +: PORT_W] = port_q;
  end

  assign addr = (phase == PH_IO) ? io_addr : pc_q;
endmodule

// File: rtl/iocyc_data.sv
module iocyc_data #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] acc
);
  logic [DATA_W-1:0] acc_q, acc_d;

  always_comb acc_d = load ? rd_data : acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/iocyc_seq.sv
module iocyc_seq
  import iocyc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2 * DATA_W,
  parameter int T_STATES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_out,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              io_sel,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_oe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] acc
);
  io_phase_e phase;
  logic      t_first, t_last, op_out;
  logic      in_cycle, strobe, io_wr, acc_load;

  iocyc_ctrl #(.T_STATES(T_STATES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .is_out(is_out),
    .phase(phase), .t_first(t_first), .t_last(t_last), .op_out(op_out)
  );

  iocyc_addr #(.PORT_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .phase(phase), .t_last(t_last),
    .rd_data(rd_data), .addr(addr)
  );

  assign acc_load = t_last && (phase == PH_IO) && !op_out;

  iocyc_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .load(acc_load), .rd_data(rd_data), .acc(acc)
  );

  assign in_cycle = (phase == PH_FETCH) || (phase == PH_OPER) || (phase == PH_IO);
  assign strobe   = in_cycle && !t_first;
  assign io_wr    = (phase == PH_IO) && op_out;

  assign io_sel  = (phase == PH_IO);
  assign rd_n    = !(strobe && !io_wr);
  assign wr_n    = !(strobe && io_wr);
  assign wr_oe   = strobe && io_wr;
  assign wr_data = acc;
  assign busy    = in_cycle;
  assign done    = (phase == PH_DONE);
endmodule

// File: rtl/iocyc_seq_chk.sv
module iocyc_seq_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              io_sel,
  input logic              rd_n,
  input logic              wr_n,
  input logic              wr_oe,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] acc
);
  // R5: the two strobes are never active together
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R4: the upper address byte repeats the lower byte in the I/O cycle
  a_r4_addr_dup: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> (addr[ADDR_W-1 -: DATA_W] == addr[DATA_W-1:0]));

  // R1: a fall of busy is followed at once by done
  a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R1: done is never high together with busy
  a_r1_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5: both strobes are high in the first T-state of a new instruction
  a_r5_t1_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rd_n && wr_n));

  // R7: write strobe only in the I/O space, with the data driven
  a_r7_wr_in_io: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (io_sel && wr_oe));

  // R2: the space select is only high while busy
  a_r2_sel_busy: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> busy);

  // R6: the accumulator only shows a new value in the done clock
  a_r6_acc_when: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc) |-> done);
endmodule

bind iocyc_seq iocyc_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .io_sel(io_sel), .rd_n(rd_n),
  .wr_n(wr_n), .wr_oe(wr_oe), .busy(busy), .done(done), .acc(acc)
);

// File: tb/iocyc_seq_bench.sv
module iocyc_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start, is_out;
  logic [7:0]  rd_data, wr_data, acc;
  logic [15:0] addr;
  logic        io_sel, rd_n, wr_n, wr_oe, busy, done;

  int          n_chk, n_err;
  bit          finished;
  logic [15:0] m_pc;
  logic [7:0]  m_acc;

  iocyc_seq u_iocyc_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_out(is_out),
    .rd_data(rd_data), .addr(addr), .io_sel(io_sel), .rd_n(rd_n),
    .wr_n(wr_n), .wr_data(wr_data), .wr_oe(wr_oe), .busy(busy),
    .done(done), .acc(acc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected bus values for clock n (1..11) of an instruction
  function automatic logic [15:0] exp_addr(int n, logic [15:0] pc, logic [7:0] port);
    int ph = (n - 1) / 3;
    if (ph == 0) return pc;
    if (ph == 1) return pc + 16'd1;
    return {port, port};
  endfunction

  function automatic bit exp_strobe(int n);
    return (n <= 9) && (((n - 1) % 3) != 0);
  endfunction

  task automatic run_instr(bit out, logic [7:0] port, logic [7:0] din, bit poke);
    logic [15:0] pc0 = m_pc;
    @(negedge clk);
    start   = 1'b1;
    is_out  = out;
    rd_data = 8'($urandom);
    for (int n = 1; n <= 11; n++) begin
      bit io, st;
      @(negedge clk);
      start   = poke && (n == 3 || n == 10);
      is_out  = ~out;
      rd_data = (n >= 4 && n <= 6) ? port : (n >= 7 && n <= 9) ? din : 8'($urandom);
      io = (n >= 7 && n <= 9);
      st = exp_strobe(n);
      check("R1", "busy", 16'(busy), 16'(n <= 9));
      check("R1", "done", 16'(done), 16'(n == 10));
      check("R2", "io_sel", 16'(io_sel), 16'(io));
      if (n <= 6) check("R3", "addr", addr, exp_addr(n, pc0, port));
      if (io)     check("R4", "addr", addr, exp_addr(n, pc0, port));
      check("R5", "rd_n", 16'(rd_n), 16'(!(st && !(io && out))));
      check("R5", "wr_n", 16'(wr_n), 16'(!(st && io && out)));
      check("R7", "wr_oe", 16'(wr_oe), 16'(st && io && out));
      if (st && io && out) check("R7", "wr_data", 16'(wr_data), 16'(m_acc));
      if (n == 10) begin
        if (!out) m_acc = din;
        check("R6", "acc", 16'(acc), 16'(m_acc));
      end
      if (n == 11) check("R8", "idle busy", 16'(busy), 16'h0);
    end
    start = 1'b0;
    m_pc  = pc0 + 16'd2;
  endtask

  initial begin
    n_chk = 0; n_err = 0; finished = 0;
    m_pc = 16'h0; m_acc = 8'h0;
    start = 0; is_out = 0; rd_data = 0;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "busy", 16'(busy), 16'h0);
    check("R9", "done", 16'(done), 16'h0);
    check("R9", "io_sel", 16'(io_sel), 16'h0);
    check("R9", "rd_n", 16'(rd_n), 16'h1);
    check("R9", "wr_n", 16'(wr_n), 16'h1);
    check("R9", "wr_oe", 16'(wr_oe), 16'h0);
    check("R9", "acc", 16'(acc), 16'h0);
    // Directed: extreme ports, input then output of the same byte
    run_instr(1'b0, 8'h00, 8'hA5, 1'b0);
    run_instr(1'b1, 8'hFF, 8'h3C, 1'b0);
    run_instr(1'b0, 8'hFF, 8'h00, 1'b1);   // R8 start while busy / done
    run_instr(1'b1, 8'h00, 8'hFF, 1'b1);   // R8 start while busy / done
    run_instr(1'b0, 8'h5A, 8'hFF, 1'b0);
    run_instr(1'b1, 8'h81, 8'h11, 1'b0);
    // Random mix
    for (int i = 0; i < 200; i++) begin
      run_instr(1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule